// File: doc/BRIEF.md
# Noughts-and-Crosses Terminal Command Decoder

This block sits behind a serial receiver and turns a stream of ASCII characters, one per cycle while `in_valid` is high, into decoded game commands. A placement command names a player symbol (X or O), a row digit and a column digit, and is closed by a period, so `X 1 1 .` puts an X in the top-left square and `O22.` puts an O in the centre. Three one-letter commands ask for the menu (M), a new game (S) or leaving the game (E); each is closed by a carriage return or a line feed. Letters are accepted in either case and spaces between fields are skipped.

For every complete command the block raises `cmd_valid` for one cycle, with the command kind, symbol, row and column on the same cycle. Any character that does not fit the grammar raises `cmd_err` for one cycle and drops the partial command. The game rules, the echo of typed characters and menu printing belong to other blocks.

The parser is a five-state machine. `ST_IDLE` waits for a command letter, skipping spaces, CR and LF; X/O moves to `ST_ROW`, M/S/E moves to `ST_EOL`. `ST_ROW` takes a row digit and moves to `ST_COL`; `ST_COL` takes a column digit and moves to `ST_DOT`; `ST_DOT` takes the period, fires a placement and returns to `ST_IDLE`; `ST_EOL` takes CR or LF, fires the control command and returns to `ST_IDLE`. In every state but `ST_IDLE`, a space keeps the state, and any other unexpected character fires an error and returns to `ST_IDLE`.

Top module: `ttt_cmd_parser`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cmd_valid` and `cmd_err` are 0 after that edge and any partial command is discarded, so a row digit sent first after reset is treated as an unexpected character.
- R2: A symbol letter, a row digit, a column digit and a period produce `cmd_valid` high in the cycle after the edge that accepts the period, with `cmd_type` = 0 (place), `cmd_symbol` = 0 for X and 1 for O, and `cmd_row`/`cmd_col` equal to the digit values 1 to 3.
- R3: Space (0x20) is skipped before and between all fields, and CR (0x0D) or LF (0x0A) received while idle is ignored; none of them produces a strobe.
- R4: M, S or E followed by CR or LF produce `cmd_valid` with `cmd_type` = 1 (menu), 2 (new game) or 3 (exit), and `cmd_symbol`, `cmd_row` and `cmd_col` all 0.
- R5: Lower-case x, o, m, s and e are decoded exactly like their upper-case forms.
- R6: A row or column character other than a space or the digits 1 to 3 (such as 0 or 4) raises `cmd_err` in the cycle after it is accepted.
- R7: Any other character that does not fit the grammar (an unknown letter, a missing period, a letter after a control command, a digit or period while idle) raises `cmd_err`, and the parser then decodes the next command from its start.
- R8: `cmd_valid` and `cmd_err` are each high for one cycle per accepted character at most, never together, and only in the cycle after a character was accepted.
- R9: Cycles with `in_valid` low change no parser state and produce no strobe; a command may be spread over characters separated by idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is present on `in_data` this cycle |
| in_data | input | 8 | ASCII character |
| cmd_valid | output | 1 | One-cycle strobe: a command was decoded |
| cmd_type | output | 2 | 0 place, 1 menu, 2 new game, 3 exit |
| cmd_symbol | output | 1 | 0 for X, 1 for O (0 for control commands) |
| cmd_row | output | 2 | Row 1 to 3 (0 for control commands) |
| cmd_col | output | 2 | Column 1 to 3 (0 for control commands) |
| cmd_err | output | 1 | One-cycle strobe: malformed input |

## Verification
The bench builds the block with its default board size of three, so the two-bit row and column fields and the in-range digits 1 to 3 are exactly those of the game, and the digits 0 and 4 sit directly on both sides of the accepted range. With that setting every state, every transition and every error exit of the machine is reachable by short character sequences, which the bench covers with directed strings and with random commands of random case, spacing, idle gaps and error positions.

// File: rtl/ttt_cmd_pkg.sv
package ttt_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_DOT  = 3'd3,
        ST_EOL  = 3'd4
    } parse_state_t;

    typedef enum logic [1:0] {
        CMD_PLACE = 2'd0,
        CMD_MENU  = 2'd1,
        CMD_START = 2'd2,
        CMD_EXIT  = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        logic space;
        logic eol;
        logic dot;
        logic sym_x;
        logic sym_o;
        logic menu;
        logic start;
        logic quit;
        logic digit_ok;
    } char_class_t;

endpackage

// File: rtl/ttt_char_class.sv
module ttt_char_class
    import ttt_cmd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BOARD_N = 3,
    localparam int COORD_W = $clog2(BOARD_N + 1)
) (
    input  logic [DATA_W-1:0]  data,
    output char_class_t        cls,
    output logic [COORD_W-1:0] digit
);

    localparam logic [DATA_W-1:0] ZERO_CH = DATA_W'(8'h30);
    localparam logic [DATA_W-1:0] DIG_MIN = DATA_W'(8'h31);
    localparam logic [DATA_W-1:0] DIG_MAX = DATA_W'(8'h30 + BOARD_N);

    logic [DATA_W-1:0] folded;

    always_comb begin
        if (data >= DATA_W'(8'h41) && data <= DATA_W'(8'h5A)) begin
            folded = data | DATA_W'(8'h20);
        end else begin
            folded = data;
        end
    end

    always_comb begin
        cls.space    = (data == DATA_W'(8'h20));
        cls.eol      = (data == DATA_W'(8'h0D)) || (data == DATA_W'(8'h0A));
        cls.dot      = (data == DATA_W'(8'h2E));
        cls.sym_x    = (folded == DATA_W'(8'h78));
        cls.sym_o    = (folded == DATA_W'(8'h6F));
        cls.menu     = (folded == DATA_W'(8'h6D));
        cls.start    = (folded == DATA_W'(8'h73));
        cls.quit     = (folded == DATA_W'(8'h65));
        cls.digit_ok = (data >= DIG_MIN) && (data <= DIG_MAX);
        digit        = COORD_W'(data - ZERO_CH);
    end

endmodule

// File: rtl/ttt_parse_fsm.sv
module ttt_parse_fsm
    import ttt_cmd_pkg::*;
#(
    parameter int BOARD_N = 3,
    localparam int COORD_W = $clog2(BOARD_N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  char_class_t        cls,
    input  logic [COORD_W-1:0] digit,
    output logic               cmd_valid,
    output cmd_kind_t          cmd_type,
    output logic               cmd_symbol,
    output logic [COORD_W-1:0] cmd_row,
    output logic [COORD_W-1:0] cmd_col,
    output logic               cmd_err
);

    parse_state_t       state_q, state_d;
    cmd_kind_t          kind_q, kind_d;
    logic               sym_q, sym_d;
    logic [COORD_W-1:0] row_q, row_d;
    logic [COORD_W-1:0] col_q, col_d;
    logic               fire, fault;

    // Next-state and field capture
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        sym_d   = sym_q;
        row_d   = row_q;
        col_d   = col_q;
        fire    = 1'b0;
        fault   = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cls.space || cls.eol) begin
                        state_d = ST_IDLE;
                    end else if (cls.sym_x || cls.sym_o) begin
                        kind_d  = CMD_PLACE;
                        sym_d   = cls.sym_o;
                        row_d   = '0;
                        col_d   = '0;
                        state_d = ST_ROW;
                    end else if (cls.menu || cls.start || cls.quit) begin
                        kind_d  = cls.menu ? CMD_MENU : (cls.start ? CMD_START : CMD_EXIT);
                        sym_d   = 1'b0;
                        row_d   = '0;
                        col_d   = '0;
                        state_d = ST_EOL;
                    end else begin
                        fault = 1'b1;
                    end
                end
                ST_ROW: begin
                    if (cls.digit_ok) begin
                        row_d   = digit;
                        state_d = ST_COL;
                    end else if (!cls.space) begin
                        fault   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                ST_COL: begin
                    if (cls.digit_ok) begin
                        col_d   = digit;
                        state_d = ST_DOT;
                    end else if (!cls.space) begin
                        fault   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                ST_DOT: begin
                    if (cls.dot) begin
                        fire    = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!cls.space) begin
                        fault   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                ST_EOL: begin
                    if (cls.eol) begin
                        fire    = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!cls.space) begin
                        fault   = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    fault   = 1'b1;
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= CMD_PLACE;
            sym_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            sym_q   <= sym_d;
            row_q   <= row_d;
            col_q   <= col_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            cmd_err    <= 1'b0;
            cmd_type   <= CMD_PLACE;
            cmd_symbol <= 1'b0;
            cmd_row    <= '0;
            cmd_col    <= '0;
        end else begin
            cmd_valid <= fire;
            cmd_err   <= fault;
            if (fire) begin
                cmd_type   <= kind_q;
                cmd_symbol <= sym_q;
                cmd_row    <= row_q;
                cmd_col    <= col_q;
            end
        end
    end

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(state_q) && !cmd_valid && !cmd_err));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_err));

    assert_err_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (state_q == ST_IDLE));

    assert_ctl_fields_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type != CMD_PLACE) |->
            (cmd_symbol == 1'b0 && cmd_row == '0 && cmd_col == '0));

    assert_place_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == CMD_PLACE) |->
            (cmd_row != '0 && cmd_row <= COORD_W'(BOARD_N) &&
             cmd_col != '0 && cmd_col <= COORD_W'(BOARD_N)));

    assert_done_in_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (state_q == ST_IDLE));

endmodule

// File: rtl/ttt_cmd_parser.sv
module ttt_cmd_parser
    import ttt_cmd_pkg::*;
#(
    parameter int BOARD_N = 3,
    localparam int COORD_W = $clog2(BOARD_N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               cmd_valid,
    output logic [1:0]         cmd_type,
    output logic               cmd_symbol,
    output logic [COORD_W-1:0] cmd_row,
    output logic [COORD_W-1:0] cmd_col,
    output logic               cmd_err
);

    char_class_t        cls_w;
    logic [COORD_W-1:0] digit_w;
    cmd_kind_t          kind_w;

    ttt_char_class #(
        .DATA_W  (8),
        .BOARD_N (BOARD_N)
    ) u_class (
        .data  (in_data),
        .cls   (cls_w),
        .digit (digit_w)
    );

    ttt_parse_fsm #(
        .BOARD_N (BOARD_N)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cls        (cls_w),
        .digit      (digit_w),
        .cmd_valid  (cmd_valid),
        .cmd_type   (kind_w),
        .cmd_symbol (cmd_symbol),
        .cmd_row    (cmd_row),
        .cmd_col    (cmd_col),
        .cmd_err    (cmd_err)
    );

    assign cmd_type = kind_w;

endmodule

// File: tb/ttt_cmd_parser_tb_top.sv
module ttt_cmd_parser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int K_NONE = 0;
    localparam int K_CMD  = 1;
    localparam int K_ERR  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       cmd_valid;
    logic [1:0] cmd_type;
    logic       cmd_symbol;
    logic [1:0] cmd_row;
    logic [1:0] cmd_col;
    logic       cmd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ttt_cmd_parser #(.BOARD_N(3)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .cmd_valid  (cmd_valid),
        .cmd_type   (cmd_type),
        .cmd_symbol (cmd_symbol),
        .cmd_row    (cmd_row),
        .cmd_col    (cmd_col),
        .cmd_err    (cmd_err)
    );

    function automatic bit mismatch(input int kind, input logic [1:0] t, input logic s,
                                    input logic [1:0] r, input logic [1:0] c);
        if (kind == K_NONE) return cmd_valid || cmd_err;
        if (kind == K_ERR)  return !cmd_err || cmd_valid;
        return !cmd_valid || cmd_err || cmd_type != t || cmd_symbol != s ||
               cmd_row != r || cmd_col != c;
    endfunction

    task automatic expect_out(input int kind, input logic [1:0] t, input logic s,
                              input logic [1:0] r, input logic [1:0] c, input string req);
        checks++;
        if (mismatch(kind, t, s, r, c)) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%0b type=%0d sym=%0d row=%0d col=%0d; expected kind=%0d type=%0d sym=%0d row=%0d col=%0d",
                     req, cmd_valid, cmd_err, cmd_type, cmd_symbol, cmd_row, cmd_col,
                     kind, t, s, r, c);
        end
    endtask

    task automatic send_b(input logic [7:0] b, input int kind, input logic [1:0] t,
                          input logic s, input logic [1:0] r, input logic [1:0] c,
                          input string req, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = $urandom % 256;
        expect_out(kind, t, s, r, c, req);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            expect_out(K_NONE, 0, 0, 0, 0, "R9");
        end
    endtask

    task automatic send_seq(input string str, input int kind, input logic [1:0] t,
                            input logic s, input logic [1:0] r, input logic [1:0] c,
                            input string req);
        for (int i = 0; i < str.len(); i++) begin
            if (i == str.len() - 1) send_b(str[i], kind, t, s, r, c, req, 0);
            else                    send_b(str[i], K_NONE, 0, 0, 0, 0, req, 0);
        end
    endtask

    task automatic spaces(input int gaps);
        int n = $urandom % 3;
        for (int i = 0; i < n; i++) send_b(8'h20, K_NONE, 0, 0, 0, 0, "R3", gaps);
    endtask

    function automatic logic [7:0] rand_case(input logic [7:0] ch);
        return ($urandom % 2) ? (ch | 8'h20) : ch;
    endfunction

    task automatic rand_place(input bit with_gaps);
        logic       s = 1'($urandom % 2);
        logic [1:0] r = 2'(1 + $urandom % 3);
        logic [1:0] c = 2'(1 + $urandom % 3);
        int gp = with_gaps ? 1 + $urandom % 3 : 0;
        spaces(gp);
        send_b(rand_case(s ? 8'h4F : 8'h58), K_NONE, 0, 0, 0, 0, "R5", gp);
        spaces(gp);
        send_b(8'h30 + 8'(r), K_NONE, 0, 0, 0, 0, "R2", gp);
        spaces(gp);
        send_b(8'h30 + 8'(c), K_NONE, 0, 0, 0, 0, "R2", gp);
        spaces(gp);
        send_b(8'h2E, K_CMD, 2'd0, s, r, c, "R2", gp);
    endtask

    task automatic rand_ctl();
        int idx = $urandom % 3;
        logic [7:0] letters [3] = '{8'h4D, 8'h53, 8'h45};
        spaces(0);
        send_b(rand_case(letters[idx]), K_NONE, 0, 0, 0, 0, "R5", 0);
        spaces(0);
        send_b(($urandom % 2) ? 8'h0D : 8'h0A, K_CMD, 2'(idx + 1), 0, 0, 0, "R4", 0);
    endtask

    task automatic rand_bad();
        int stage = $urandom % 5;
        logic [7:0] bad;
        string req = "R7";
        logic [7:0] idle_bad [4] = '{8'h51, 8'h23, 8'h31, 8'h2E};
        logic [7:0] dig_bad  [4] = '{8'h30, 8'h34, 8'h2E, 8'h58};
        logic [7:0] dot_bad  [3] = '{8'h31, 8'h58, 8'h2C};
        logic [7:0] eol_bad  [3] = '{8'h58, 8'h2E, 8'h4D};
        if (stage == 4) begin
            send_b(8'h53, K_NONE, 0, 0, 0, 0, "R7", 0);
            spaces(0);
            bad = eol_bad[$urandom % 3];
        end else begin
            if (stage >= 1) send_b(8'h58, K_NONE, 0, 0, 0, 0, "R7", 0);
            if (stage >= 2) send_b(8'h32, K_NONE, 0, 0, 0, 0, "R7", 0);
            if (stage >= 3) send_b(8'h33, K_NONE, 0, 0, 0, 0, "R7", 0);
            spaces(0);
            if (stage == 0)      bad = idle_bad[$urandom % 4];
            else if (stage == 3) bad = dot_bad[$urandom % 3];
            else                 bad = dig_bad[$urandom % 4];
            if ((stage == 1 || stage == 2) && (bad == 8'h30 || bad == 8'h34)) req = "R6";
        end
        send_b(bad, K_ERR, 0, 0, 0, 0, req, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_out(K_NONE, 0, 0, 0, 0, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected end of test");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out(K_NONE, 0, 0, 0, 0, "R1");

        // R2 R3: spaced placement
        send_seq("X 1 1 .", K_CMD, 2'd0, 1'b0, 2'd1, 2'd1, "R2");
        // R5: lower case, no spaces
        send_seq("o22.", K_CMD, 2'd0, 1'b1, 2'd2, 2'd2, "R5");
        send_seq("  O 3   1  .", K_CMD, 2'd0, 1'b1, 2'd3, 2'd1, "R3");
        // R4: control commands
        send_seq("M\r", K_CMD, 2'd1, 1'b0, 2'd0, 2'd0, "R4");
        send_seq("s\n", K_CMD, 2'd2, 1'b0, 2'd0, 2'd0, "R4");
        send_seq("E \r", K_CMD, 2'd3, 1'b0, 2'd0, 2'd0, "R4");
        // R3: line endings and spaces alone do nothing
        send_seq("\r\n \r", K_NONE, 0, 0, 0, 0, "R3");
        // R6: out-of-range digits
        send_seq("X 4", K_ERR, 0, 0, 0, 0, "R6");
        send_seq("x 1 0", K_ERR, 0, 0, 0, 0, "R6");
        send_seq("X 3 3 3", K_ERR, 0, 0, 0, 0, "R7");
        // R7: unexpected characters, then recovery
        send_seq("X 1 1 ,", K_ERR, 0, 0, 0, 0, "R7");
        send_seq("M X", K_ERR, 0, 0, 0, 0, "R7");
        send_seq("Q", K_ERR, 0, 0, 0, 0, "R7");
        send_seq(".", K_ERR, 0, 0, 0, 0, "R7");
        send_seq("O13.", K_CMD, 2'd0, 1'b1, 2'd1, 2'd3, "R7");
        // R1: reset discards a partial command
        send_seq("X 2", K_NONE, 0, 0, 0, 0, "R1");
        do_reset();
        send_seq("3", K_ERR, 0, 0, 0, 0, "R1");
        send_seq(".", K_ERR, 0, 0, 0, 0, "R1");
        // R9: idle gaps inside a command
        send_b(8'h58, K_NONE, 0, 0, 0, 0, "R9", 5);
        send_b(8'h31, K_NONE, 0, 0, 0, 0, "R9", 3);
        send_b(8'h32, K_NONE, 0, 0, 0, 0, "R9", 7);
        send_b(8'h2E, K_CMD, 2'd0, 1'b0, 2'd1, 2'd2, "R9", 2);

        for (int k = 0; k < 400; k++) begin
            case ($urandom % 4)
                0: rand_place(1'b0);
                1: rand_ctl();
                2: rand_bad();
                default: rand_place(1'b1);
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule